// File: doc/BRIEF.md
# Carry-Extended Add Execution Unit

This unit executes the carry-extended add family of a 32-bit fixed-point processor pipeline. Each cycle it can accept one instruction word with a valid strobe, the value of the first source register and the current carry, overflow and summary-overflow status bits. It decodes the word and forms the sum. One cycle later, from registered outputs, it returns the destination index and result, the new carry, optional overflow and summary-overflow updates, an optional nibble for condition field 0, and an illegal-instruction flag. The register file and status register live outside; this block only reports what is written, with a write enable for each destination.

The word holds three operations. The zero-extended add produces RA + carry. The minus-one add produces RA + all-ones + carry. The complement add produces ~RA + carry. The zero-extended add is the usual last step of a multi-word add chain. With RA = 0 it also turns the carry bit into a plain 0/1 integer.

Top module: `cxadd_unit`

## Requirements
- R1: The word is numbered from the MSB: instr[31:26] primary opcode, [25:21] destination index, [20:16] source-A index, [15:11] source-B index, [10] overflow-enable, [9:1] extended opcode, [0] record flag. Primary opcode 31 with extended opcode 202 selects the zero-extended add (base word 0x7C000194), 234 selects the minus-one add and 200 selects the complement add. The destination index is returned on rd_idx.
- R2: Any other opcode pair sets out_illegal and clears rd_we, ca_we, ov_we and cr0_we.
- R3: The zero-extended add returns ra_val + ca_in modulo 2^32. With ra_val = 0 the result equals ca_in.
- R4: ca_out is bit 32 of the full 33-bit sum. ca_we is 1 for every legal instruction.
- R5: The minus-one add returns ra_val + 0xFFFFFFFF + ca_in.
- R6: The complement add returns ~ra_val + ca_in.
- R7: With overflow-enable at 1, ov_we is 1 and ov_out reports signed overflow. Signed overflow means the two operands share a sign and the result sign differs from it; the carry counts as a positive addend. ov_out is 0 when no overflow occurs.
- R8: With overflow-enable at 0, ov_we is 0, ov_out equals ov_in and so_out equals so_in.
- R9: so_out is so_in OR (overflow-enable AND signed overflow). A set so_in is never cleared.
- R10: With the record flag at 1, cr0_we is 1 and cr0 = {LT, GT, EQ, SO}, MSB first. Exactly one of LT, GT and EQ is set, from a signed compare of the result with zero. SO is a copy of so_out. With the record flag at 0, cr0_we is 0.
- R11: The source-B field has no effect on any output.
- R12: Outputs are registered, one cycle after the accepted word. Synchronous reset clears every output. out_valid follows in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| ra_val | input | 32 | Value of the source-A register |
| ca_in | input | 1 | Current carry bit |
| ov_in | input | 1 | Current overflow bit |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Registered results are present |
| out_illegal | output | 1 | Word was not one of the three operations |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Result |
| rd_we | output | 1 | Write result to destination |
| ca_we | output | 1 | Write carry |
| ca_out | output | 1 | New carry |
| ov_we | output | 1 | Write overflow and summary-overflow |
| ov_out | output | 1 | New overflow bit |
| so_out | output | 1 | New summary-overflow bit |
| cr0_we | output | 1 | Write condition field 0 |
| cr0 | output | 4 | {LT, GT, EQ, SO} |

## Verification
Two functions can meet in one cycle: overflow detection and the condition-field build. When overflow-enable and the record flag are both set and the sum overflows, the SO bit of cr0 must show the summary overflow that this same instruction has just produced. The bench provokes this with 0x7FFFFFFF + 1 on the zero-extended add, 0x80000000 on the minus-one add with carry clear, and 0x80000000 on the complement add with carry set. It checks that the new overflow bit and the cr0 SO bit are both 1 in that one result.

// File: rtl/cxadd_pkg.sv
package cxadd_pkg;
  localparam int unsigned IW       = 32;
  localparam int unsigned REG_IDXW = 5;
  localparam int unsigned XOW      = 9;

  localparam logic [5:0]     PRIM_OP  = 6'd31;
  localparam logic [XOW-1:0] XO_ZEXT  = 9'd202;
  localparam logic [XOW-1:0] XO_MONE  = 9'd234;
  localparam logic [XOW-1:0] XO_CMPL  = 9'd200;

  typedef enum logic [1:0] {
    OPK_ZEXT = 2'd0,
    OPK_MONE = 2'd1,
    OPK_CMPL = 2'd2
  } opk_e;

  typedef struct packed {
    logic                legal;
    opk_e                kind;
    logic [REG_IDXW-1:0] dst;
    logic                ovf_en;
    logic                rec;
  } dec_t;
endpackage

// File: rtl/cxadd_decode.sv
module cxadd_decode
  import cxadd_pkg::*;
(
  input  logic [IW-1:0] word,
  output dec_t          dec
);
  logic [5:0]     prim;
  logic [XOW-1:0] ext;

  always_comb begin
    prim       = word[31:26];
    ext        = word[9:1];
    dec.dst    = word[25:21];
    dec.ovf_en = word[10];
    dec.rec    = word[0];
    dec.legal  = 1'b0;
    dec.kind   = OPK_ZEXT;
    if (prim == PRIM_OP) begin
      unique case (ext)
        XO_ZEXT: begin dec.legal = 1'b1; dec.kind = OPK_ZEXT; end
        XO_MONE: begin dec.legal = 1'b1; dec.kind = OPK_MONE; end
        XO_CMPL: begin dec.legal = 1'b1; dec.kind = OPK_CMPL; end
        default: begin dec.legal = 1'b0; dec.kind = OPK_ZEXT; end
      endcase
    end
  end
endmodule

// File: rtl/cxadd_alu.sv
module cxadd_alu
  import cxadd_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  opk_e         kind,
  input  logic [W-1:0] a_in,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         sovf
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  opa;
  logic [W-1:0]  opb;
  logic [SW-1:0] full;

  always_comb begin
    unique case (kind)
      OPK_MONE: begin opa = a_in;  opb = {W{1'b1}}; end
      OPK_CMPL: begin opa = ~a_in; opb = '0;        end
      default:  begin opa = a_in;  opb = '0;        end
    endcase
    full = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[SW-1];
    sovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
  end
endmodule

// File: rtl/cxadd_flags.sv
module cxadd_flags #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res,
  input  logic         sovf,
  input  logic         ovf_en,
  input  logic         ov_prev,
  input  logic         so_prev,
  output logic         ov_new,
  output logic         so_new,
  output logic [3:0]   cr_new
);
  logic neg, zero;

  always_comb begin
    neg    = res[W-1];
    zero   = (res == '0);
    ov_new = ovf_en ? sovf : ov_prev;
    so_new = so_prev | (ovf_en & sovf);
    cr_new = {neg, !neg && !zero, zero, so_new};
  end
endmodule

// File: rtl/cxadd_unit.sv
module cxadd_unit
  import cxadd_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] ra_val,
  input  logic            ca_in,
  input  logic            ov_in,
  input  logic            so_in,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_we,
  output logic            ca_we,
  output logic            ca_out,
  output logic            ov_we,
  output logic            ov_out,
  output logic            so_out,
  output logic            cr0_we,
  output logic [3:0]      cr0
);
  dec_t            dec;
  logic [XLEN-1:0] sum;
  logic            cout, sovf, ov_n, so_n;
  logic [3:0]      cr_n;
  logic            ok;

  cxadd_decode u_dec (.word(instr), .dec(dec));

  cxadd_alu #(.W(XLEN)) u_alu (
    .kind(dec.kind), .a_in(ra_val), .cin(ca_in),
    .sum(sum), .cout(cout), .sovf(sovf)
  );

  cxadd_flags #(.W(XLEN)) u_flg (
    .res(sum), .sovf(sovf), .ovf_en(dec.ovf_en),
    .ov_prev(ov_in), .so_prev(so_in),
    .ov_new(ov_n), .so_new(so_n), .cr_new(cr_n)
  );

  assign ok = in_valid && dec.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      rd_idx      <= '0;
      rd_data     <= '0;
      rd_we       <= 1'b0;
      ca_we       <= 1'b0;
      ca_out      <= 1'b0;
      ov_we       <= 1'b0;
      ov_out      <= 1'b0;
      so_out      <= 1'b0;
      cr0_we      <= 1'b0;
      cr0         <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && !dec.legal;
      rd_idx      <= dec.dst;
      rd_data     <= sum;
      rd_we       <= ok;
      ca_we       <= ok;
      ca_out      <= cout;
      ov_we       <= ok && dec.ovf_en;
      ov_out      <= dec.legal ? ov_n : ov_in;
      so_out      <= dec.legal ? so_n : so_in;
      cr0_we      <= ok && dec.rec;
      cr0         <= cr_n;
    end
  end

  // R2: an illegal word writes nothing
  a_r2_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !rd_we && !ca_we && !ov_we && !cr0_we);

  // R10: exactly one of LT/GT/EQ in a written field
  a_r10_cr_onehot: assert property (@(posedge clk) disable iff (rst)
    cr0_we |-> $countones(cr0[3:1]) == 1);

  // R9: a set summary-overflow input stays set
  a_r9_so_sticky: assert property (@(posedge clk) disable iff (rst)
    (in_valid && so_in) |=> so_out);

  // R12: valid follows with one cycle of latency
  a_r12_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8: overflow-enable clear never writes overflow
  a_r8_no_ov_write: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !instr[10]) |=> !ov_we);

  // R4: every result write comes with a carry write
  a_r4_carry_always: assert property (@(posedge clk) disable iff (rst)
    rd_we |-> ca_we);
endmodule

// File: tb/cxadd_unit_bench.sv
`timescale 1ns/1ps
module cxadd_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr;
  logic [31:0] ra_val;
  logic        ca_in, ov_in, so_in;
  logic        out_valid, out_illegal, rd_we, ca_we, ca_out;
  logic        ov_we, ov_out, so_out, cr0_we;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic [3:0]  cr0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cxadd_unit u_cxadd_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .ra_val(ra_val), .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in),
    .out_valid(out_valid), .out_illegal(out_illegal), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_we(rd_we), .ca_we(ca_we), .ca_out(ca_out),
    .ov_we(ov_we), .ov_out(ov_out), .so_out(so_out),
    .cr0_we(cr0_we), .cr0(cr0)
  );

  function automatic logic [31:0] mk(input logic [5:0] prim, input logic [8:0] xo,
                                     input logic [4:0] rd, input logic [4:0] rb,
                                     input logic oe, input logic rc);
    return {prim, rd, 5'd3, rb, oe, xo, rc};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, result appears after next posedge, sampled at following negedge
  task automatic issue(input logic [31:0] w, input logic [31:0] a,
                       input logic c, input logic o, input logic s);
    instr = w; ra_val = a; ca_in = c; ov_in = o; so_in = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // {xo, oe, rc, ra, ca, so_in, res, ca, ov, so, cr}
  localparam int NV = 11;
  localparam logic [83:0] VEC [NV] = '{
    {9'd202, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'b0010},
    {9'd202, 1'b1, 1'b1, 32'h7FFFFFFF, 1'b1, 1'b0, 32'h80000000, 1'b0, 1'b1, 1'b1, 4'b1001},
    {9'd202, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 32'h00000001, 1'b0, 1'b0, 1'b0, 4'b0100},
    {9'd202, 1'b0, 1'b1, 32'h00000000, 1'b0, 1'b1, 32'h00000000, 1'b0, 1'b0, 1'b1, 4'b0011},
    {9'd234, 1'b1, 1'b1, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 4'b1000},
    {9'd234, 1'b1, 1'b1, 32'h00000000, 1'b1, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'b0010},
    {9'd234, 1'b1, 1'b1, 32'h80000000, 1'b0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b1, 4'b0101},
    {9'd200, 1'b1, 1'b1, 32'h00000000, 1'b1, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'b0010},
    {9'd200, 1'b1, 1'b1, 32'h80000000, 1'b1, 1'b1, 32'h80000000, 1'b0, 1'b1, 1'b1, 4'b1001},
    {9'd200, 1'b0, 1'b1, 32'h00000005, 1'b0, 1'b0, 32'hFFFFFFFA, 1'b0, 1'b0, 1'b0, 4'b1000},
    {9'd202, 1'b1, 1'b1, 32'h00001234, 1'b0, 1'b1, 32'h00001234, 1'b0, 1'b0, 1'b1, 4'b0101}
  };

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; instr = '0; ra_val = '0;
    ca_in = 1'b0; ov_in = 1'b0; so_in = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R12 reset data", rd_data, 32'd0);
    chk("R12 reset enables", {28'd0, rd_we, ca_we, ov_we, cr0_we}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [83:0] v;
      v = VEC[i];
      issue(mk(6'd31, v[83:75], 5'd9, 5'd0, v[74], v[73]), v[72:41], v[40], 1'b0, v[39]);
      // R3 R5 R6 result, R4 carry, R7 overflow, R9 sticky, R10 field
      chk($sformatf("R3/R5/R6 result vec%0d", i), rd_data, v[38:7]);
      chk($sformatf("R4 carry vec%0d", i), {30'd0, ca_we, ca_out}, {30'd0, 1'b1, v[6]});
      chk($sformatf("R7 ov vec%0d", i), {30'd0, ov_we, ov_out}, {30'd0, v[74], v[5]});
      chk($sformatf("R9 so vec%0d", i), {31'd0, so_out}, {31'd0, v[4]});
      chk($sformatf("R10 cr0 vec%0d", i), {27'd0, cr0_we, cr0}, {27'd0, 1'b1, v[3:0]});
      chk($sformatf("R12 valid vec%0d", i), {31'd0, out_valid}, 32'd1);
    end

    // R1: base word decodes, destination index returned
    issue(32'h7C000194 | (32'd17 << 21), 32'h0000000A, 1'b1, 1'b0, 1'b0);
    chk("R1 base word data", rd_data, 32'h0000000B);
    chk("R1 dst index", {27'd0, rd_idx}, 32'd17);
    chk("R1 legal", {30'd0, out_illegal, rd_we}, 32'd1);

    // R7: OE=1 without overflow clears an incoming overflow bit
    issue(mk(6'd31, 9'd202, 5'd1, 5'd0, 1'b1, 1'b0), 32'h00000010, 1'b0, 1'b1, 1'b0);
    chk("R7 ov cleared", {30'd0, ov_we, ov_out}, {30'd0, 1'b1, 1'b0});
    chk("R10 no record", {31'd0, cr0_we}, 32'd0);

    // R8: OE=0 with overflow leaves ov/so unchanged
    issue(mk(6'd31, 9'd202, 5'd1, 5'd0, 1'b0, 1'b0), 32'h7FFFFFFF, 1'b1, 1'b1, 1'b0);
    chk("R8 ov untouched", {29'd0, ov_we, ov_out, so_out}, {29'd0, 1'b0, 1'b1, 1'b0});

    // R11: source-B field ignored
    issue(mk(6'd31, 9'd234, 5'd2, 5'd31, 1'b1, 1'b1), 32'h00000005, 1'b1, 1'b0, 1'b0);
    chk("R11 rb ignored data", rd_data, 32'h00000005);
    chk("R11 rb ignored flags", {25'd0, ca_out, ov_out, so_out, cr0}, {25'd0, 1'b1, 1'b0, 1'b0, 4'b0100});

    // R2: bad extended opcode and bad primary opcode
    issue(mk(6'd31, 9'd203, 5'd2, 5'd0, 1'b1, 1'b1), 32'h1, 1'b1, 1'b0, 1'b0);
    chk("R2 bad xo", {27'd0, out_illegal, rd_we, ca_we, ov_we, cr0_we}, 32'h10);
    issue(mk(6'd30, 9'd202, 5'd2, 5'd0, 1'b1, 1'b1), 32'h1, 1'b1, 1'b0, 1'b0);
    chk("R2 bad prim", {27'd0, out_illegal, rd_we, ca_we, ov_we, cr0_we}, 32'h10);

    // R12: idle cycle drops valid
    @(negedge clk);
    chk("R12 idle", {30'd0, out_valid, out_illegal}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule